// File: doc/BRIEF.md
# Packed Dot-Product Accumulate Unit

This block is a SIMD integer datapath that splits its operand vectors into 32-bit lanes. In each lane it forms a short dot product of the two source vectors and adds that dot product to the lane's accumulator word. There are two element sizes. Byte mode multiplies four unsigned bytes of A by four signed bytes of B. Halfword mode multiplies two pairs of signed 16-bit elements. The final add either wraps modulo 2^32 or clamps to the signed 32-bit range.

A per-lane enable mask selects which lanes take the computed value. A disabled lane either keeps its accumulator word (merge) or becomes zero (zeroing). The active vector width is chosen per operation: half of the lanes (128 bits) or all of them (256 bits). Lanes above the active width are always zero.

The result passes through one register stage. A small output-control state machine has two states. OUT_IDLE means no new result is presented. OUT_LIVE means the result register was loaded on the previous edge. Transitions:
- from either state to OUT_LIVE when `in_valid` is high;
- from either state to OUT_IDLE when `in_valid` is low;
- to OUT_IDLE on reset.

Top module: `dot_acc_unit`

## Requirements
- R1: With opcode 2'b00, lane j of the result (bits 32j+31:32j) equals the accumulator lane plus the sum of four products, wrapped modulo 2^32. Each product is formed from a byte of `src_a` at bits 32j+8k+7:32j+8k (k=0..3), taken as unsigned, and the matching byte of `src_b`, taken as signed.
- R2: With opcode 2'b10, lane j equals the accumulator lane plus the sum of two products, wrapped modulo 2^32. Each product is formed from a signed 16-bit element of `src_a` at bits 32j+16k+15:32j+16k (k=0,1) and the matching signed element of `src_b`.
- R3: Opcodes 2'b01 (byte) and 2'b11 (halfword) form the same exact sum without intermediate overflow. They then clamp it to the range -2^31 to 2^31-1.
- R4: The wrapping opcodes never clamp. For example, a lane whose accumulator is 0 and whose two halfword products are each (-32768)*(-32768) gives 32'h8000_0000.
- R5: Bit 1 of the opcode selects the element size (0 = byte, 1 = halfword). Bit 0 selects saturation (1 = clamp).
- R6: `wide`=0 makes lanes 0..LANES/2-1 active. `wide`=1 makes all LANES lanes active. Every lane at or above the active count reads zero.
- R7: An active lane whose `lane_mask` bit j is 1 gets the computed value.
- R8: An active lane whose mask bit is 0 gets the accumulator lane unchanged when `zero_mode`=0.
- R9: A lane whose mask bit is 0 reads zero when `zero_mode`=1.
- R10: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. The result updates only on such cycles and otherwise holds.
- R11: While `rst` is sampled high at a clock edge, `out_valid` and `result` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands valid this cycle |
| op | input | 2 | Bit 1: halfword mode; bit 0: saturating |
| wide | input | 1 | 1 = all lanes active, 0 = lower half only |
| zero_mode | input | 1 | 1 = disabled lanes read zero, 0 = keep accumulator |
| lane_mask | input | LANES | Per-lane write enable |
| acc_in | input | LANES*32 | Accumulator vector |
| src_a | input | LANES*32 | Source A (bytes unsigned / halfwords signed) |
| src_b | input | LANES*32 | Source B (signed) |
| out_valid | output | 1 | Result valid |
| result | output | LANES*32 | Registered result vector |

## Verification
The hardest case to reach from the ports is a saturation boundary where the accumulator and the products push the exact sum just past ±2^31. Uniform random operands almost never produce it. To reach it, the stimulus builds operands from biased bytes: the extremes 0x00, 0xFF, 0x80 and 0x7F are chosen far more often than chance, so halfwords of -32768 and 32767 and bytes of 255 and -128 appear in many lanes. Directed vectors then pin the accumulator at the 32-bit limits with all-extreme sources, for every opcode, width, mask pattern and masking mode.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
    localparam int LANE_W          = 32;
    localparam int BYTE_W          = 8;
    localparam int HALF_W          = 16;
    localparam int BYTES_PER_LANE  = LANE_W / BYTE_W;
    localparam int HALVES_PER_LANE = LANE_W / HALF_W;
    // exact-sum width: room for accumulator plus worst-case products
    localparam int SUM_W           = LANE_W + 4;

    typedef enum logic [1:0] {
        OP_BYTE_WRAP = 2'b00,
        OP_BYTE_SAT  = 2'b01,
        OP_HALF_WRAP = 2'b10,
        OP_HALF_SAT  = 2'b11
    } dpa_op_e;

    typedef enum logic {
        OUT_IDLE = 1'b0,
        OUT_LIVE = 1'b1
    } dpa_state_e;
endpackage

// File: rtl/dpa_lane.sv
module dpa_lane
    import dpa_pkg::*;
(
    input  dpa_op_e           op,
    input  logic [LANE_W-1:0] acc,
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    output logic [LANE_W-1:0] res,
    output logic              sum_neg
);
    localparam logic [LANE_W-1:0] POS_LIMIT = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic [LANE_W-1:0] NEG_LIMIT = {1'b1, {(LANE_W-1){1'b0}}};

    logic signed [SUM_W-1:0] bprod [BYTES_PER_LANE];
    logic signed [SUM_W-1:0] hprod [HALVES_PER_LANE];
    logic signed [SUM_W-1:0] byte_sum, half_sum, exact;
    logic [SUM_W-LANE_W:0]   upper;
    logic                    is_half, is_sat, ovf;

    // unsigned A byte times signed B byte, extended to the exact-sum width
    for (genvar k = 0; k < BYTES_PER_LANE; k++) begin : g_byte
        assign bprod[k] = SUM_W'($signed({1'b0, a[BYTE_W*k +: BYTE_W]}))
                        * SUM_W'($signed(b[BYTE_W*k +: BYTE_W]));
    end

    // signed halfword times signed halfword
    for (genvar k = 0; k < HALVES_PER_LANE; k++) begin : g_half
        assign hprod[k] = SUM_W'($signed(a[HALF_W*k +: HALF_W]))
                        * SUM_W'($signed(b[HALF_W*k +: HALF_W]));
    end

    always_comb begin
        is_half  = op[1];
        is_sat   = op[0];
        byte_sum = '0;
        for (int k = 0; k < BYTES_PER_LANE; k++) begin
            byte_sum = byte_sum + bprod[k];
        end
        half_sum = '0;
        for (int k = 0; k < HALVES_PER_LANE; k++) begin
            half_sum = half_sum + hprod[k];
        end
        exact   = SUM_W'($signed(acc)) + (is_half ? half_sum : byte_sum);
        upper   = exact[SUM_W-1:LANE_W-1];
        ovf     = (|upper) && !(&upper);
        sum_neg = exact[SUM_W-1];
        if (is_sat && ovf) begin
            res = sum_neg ? NEG_LIMIT : POS_LIMIT;
        end else begin
            res = exact[LANE_W-1:0];
        end
    end
endmodule

// File: rtl/dpa_wb.sv
module dpa_wb
    import dpa_pkg::*;
(
    input  logic              active,
    input  logic              enable,
    input  logic              zero_mode,
    input  logic [LANE_W-1:0] calc,
    input  logic [LANE_W-1:0] acc,
    output logic [LANE_W-1:0] out
);
    always_comb begin
        if (!active) begin
            out = '0;
        end else if (enable) begin
            out = calc;
        end else if (zero_mode) begin
            out = '0;
        end else begin
            out = acc;
        end
    end
endmodule

// File: rtl/dot_acc_unit.sv
module dot_acc_unit
    import dpa_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [1:0]              op,
    input  logic                    wide,
    input  logic                    zero_mode,
    input  logic [LANES-1:0]        lane_mask,
    input  logic [LANES*LANE_W-1:0] acc_in,
    input  logic [LANES*LANE_W-1:0] src_a,
    input  logic [LANES*LANE_W-1:0] src_b,
    output logic                    out_valid,
    output logic [LANES*LANE_W-1:0] result
);
    localparam int NARROW_LANES = LANES / 2;
    localparam int VEC_W        = LANES * LANE_W;

    dpa_op_e             op_e;
    dpa_state_e          state, state_nx;
    logic [LANE_W-1:0]   lane_res [LANES];
    logic [LANES-1:0]    lane_neg;
    logic [VEC_W-1:0]    wb_vec;

    assign op_e = dpa_op_e'(op);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic lane_active;
        if (j < NARROW_LANES) begin : g_low
            assign lane_active = 1'b1;
        end else begin : g_high
            assign lane_active = wide;
        end

        dpa_lane u_lane (
            .op      (op_e),
            .acc     (acc_in[LANE_W*j +: LANE_W]),
            .a       (src_a[LANE_W*j +: LANE_W]),
            .b       (src_b[LANE_W*j +: LANE_W]),
            .res     (lane_res[j]),
            .sum_neg (lane_neg[j])
        );

        dpa_wb u_wb (
            .active    (lane_active),
            .enable    (lane_mask[j]),
            .zero_mode (zero_mode),
            .calc      (lane_res[j]),
            .acc       (acc_in[LANE_W*j +: LANE_W]),
            .out       (wb_vec[LANE_W*j +: LANE_W])
        );

        // R3
        sat_sign_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && op[0]) |-> (lane_res[j][LANE_W-1] == lane_neg[j]));

        // R9
        zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && zero_mode && !lane_mask[j])
            |=> (result[LANE_W*j +: LANE_W] == '0));

        // R8
        merge_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !zero_mode && !lane_mask[j] && lane_active)
            |=> (result[LANE_W*j +: LANE_W] == $past(acc_in[LANE_W*j +: LANE_W])));

        if (j >= NARROW_LANES) begin : g_upper_chk
            // R6
            upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
                (in_valid && !wide) |=> (result[LANE_W*j +: LANE_W] == '0));
        end
    end

    // next-state logic
    always_comb begin
        unique case (state)
            OUT_IDLE: state_nx = in_valid ? OUT_LIVE : OUT_IDLE;
            OUT_LIVE: state_nx = in_valid ? OUT_LIVE : OUT_IDLE;
            default:  state_nx = OUT_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= OUT_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
        end else if (in_valid) begin
            result <= wb_vec;
        end
    end

    assign out_valid = (state == OUT_LIVE);

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R10
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));
endmodule

// File: tb/sim_dot_acc_unit.sv
module sim_dot_acc_unit;
    localparam int LANES = 8;
    localparam int VW    = LANES * 32;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [1:0]       op = 2'b00;
    logic             wide = 1'b0;
    logic             zero_mode = 1'b0;
    logic [LANES-1:0] lane_mask = '0;
    logic [VW-1:0]    acc_in = '0;
    logic [VW-1:0]    src_a = '0;
    logic [VW-1:0]    src_b = '0;
    logic             out_valid;
    logic [VW-1:0]    result;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dot_acc_unit #(.LANES(LANES)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .wide(wide),
        .zero_mode(zero_mode), .lane_mask(lane_mask), .acc_in(acc_in),
        .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result)
    );

    function automatic logic [31:0] ref_lane(input logic [1:0] o,
                                             input logic [31:0] acc,
                                             input logic [31:0] a,
                                             input logic [31:0] b);
        longint s;
        s = longint'($signed(acc));
        if (!o[1]) begin
            for (int k = 0; k < 4; k++)
                s += longint'({1'b0, a[8*k +: 8]}) * longint'($signed(b[8*k +: 8]));
        end else begin
            for (int k = 0; k < 2; k++)
                s += longint'($signed(a[16*k +: 16])) * longint'($signed(b[16*k +: 16]));
        end
        if (o[0]) begin
            if (s > 64'sd2147483647)  s = 64'sd2147483647;
            if (s < -64'sd2147483648) s = -64'sd2147483648;
        end
        return s[31:0];
    endfunction

    function automatic logic [7:0] pick_byte();
        case ($urandom % 6)
            0: return 8'h00;
            1: return 8'hFF;
            2: return 8'h80;
            3: return 8'h7F;
            default: return 8'($urandom);
        endcase
    endfunction

    function automatic logic [VW-1:0] biased_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < VW / 8; i++) v[8*i +: 8] = pick_byte();
        return v;
    endfunction

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic check_word(input string tag, input int lane,
                              input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s lane %0d: actual=%h expected=%h", tag, lane, act, exp);
        end
    endtask

    // drive one operation, then check the result and the idle cycle after it
    task automatic run_op(input logic [1:0] o, input logic w, input logic zm,
                          input logic [LANES-1:0] m, input logic [VW-1:0] acc,
                          input logic [VW-1:0] a, input logic [VW-1:0] b);
        logic [VW-1:0] exp_vec;
        int active;
        string tag;
        active = w ? LANES : LANES / 2;
        for (int j = 0; j < LANES; j++) begin
            if (j >= active)      exp_vec[32*j +: 32] = '0;
            else if (m[j])        exp_vec[32*j +: 32] = ref_lane(o, acc[32*j +: 32], a[32*j +: 32], b[32*j +: 32]);
            else if (zm)          exp_vec[32*j +: 32] = '0;
            else                  exp_vec[32*j +: 32] = acc[32*j +: 32];
        end
        @(negedge clk);
        in_valid = 1'b1; op = o; wide = w; zero_mode = zm;
        lane_mask = m; acc_in = acc; src_a = a; src_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        src_a = biased_vec(); src_b = biased_vec(); acc_in = biased_vec();
        check_bit("R10 out_valid after in_valid", out_valid, 1'b1);
        for (int j = 0; j < LANES; j++) begin
            if (j >= active)      tag = "R6 inactive lane";
            else if (!m[j])       tag = zm ? "R9 zeroed lane" : "R8 merged lane";
            else if (o[0])        tag = "R3 saturating";
            else if (o[1])        tag = "R2 halfword wrap";
            else                  tag = "R1 byte wrap";
            check_word(tag, j, result[32*j +: 32], exp_vec[32*j +: 32]);
        end
        @(negedge clk);
        check_bit("R10 out_valid idle", out_valid, 1'b0);
        n_checks++;
        if (result !== exp_vec) begin
            n_fail++;
            $display("FAIL R10 hold: actual=%h expected=%h", result, exp_vec);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R10 watchdog: actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [VW-1:0] all_min_h, all_max_h, all_ff, all_80, acc_max, acc_min;
        logic [7:0] masks [6];
        masks[0] = 8'hFF; masks[1] = 8'h00; masks[2] = 8'hA5;
        masks[3] = 8'h5A; masks[4] = 8'h0F; masks[5] = 8'hF0;

        repeat (3) @(negedge clk);
        // R11 reset state
        check_bit("R11 reset out_valid", out_valid, 1'b0);
        check_word("R11 reset result", 0, result[31:0], 32'h0);
        n_checks++;
        if (result !== '0) begin
            n_fail++;
            $display("FAIL R11 reset vector: actual=%h expected=0", result);
        end
        rst = 1'b0;

        all_min_h = {LANES*2{16'h8000}};
        all_max_h = {LANES*2{16'h7FFF}};
        all_ff    = {LANES*4{8'hFF}};
        all_80    = {LANES*4{8'h80}};
        acc_max   = {LANES{32'h7FFF_FFFF}};
        acc_min   = {LANES{32'h8000_0000}};

        // R4: two (-32768)^2 products wrap to 0x80000000 with acc 0
        run_op(2'b10, 1'b1, 1'b0, 8'hFF, '0, all_min_h, all_min_h);
        check_word("R4 wrap min*min", 0, result[31:0], 32'h8000_0000);
        // R3: same with clamp gives max
        run_op(2'b11, 1'b1, 1'b0, 8'hFF, '0, all_min_h, all_min_h);
        check_word("R3 clamp min*min", 0, result[31:0], 32'h7FFF_FFFF);
        // R3: positive push from max accumulator
        run_op(2'b11, 1'b1, 1'b1, 8'hFF, acc_max, all_max_h, all_max_h);
        // R3 and R4: byte 255 * -128 from the negative limit
        run_op(2'b01, 1'b1, 1'b0, 8'hFF, acc_min, all_ff, all_80);
        check_word("R3 byte clamp low", 0, result[31:0], 32'h8000_0000);
        run_op(2'b00, 1'b1, 1'b0, 8'hFF, acc_min, all_ff, all_80);
        check_word("R4 byte wrap low", 0, result[31:0], 32'h8000_0000 - 32'd130560);
        // R5 / R7: opcode bits with all lanes enabled
        run_op(2'b00, 1'b0, 1'b0, 8'hFF, acc_max, all_ff, all_ff);

        // near-exhaustive sweep over opcode, width, masking mode and mask pattern
        for (int o = 0; o < 4; o++)
            for (int w = 0; w < 2; w++)
                for (int zm = 0; zm < 2; zm++)
                    for (int mi = 0; mi < 6; mi++)
                        for (int r = 0; r < 4; r++)
                            run_op(2'(o), 1'(w), 1'(zm), masks[mi],
                                   (r == 0) ? acc_max : (r == 1) ? acc_min : biased_vec(),
                                   biased_vec(), biased_vec());

        // R11: reset in the middle clears a loaded result
        @(negedge clk);
        in_valid = 1'b1; op = 2'b00; wide = 1'b1; lane_mask = 8'hFF;
        acc_in = acc_max; rst = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b0;
        check_bit("R11 mid reset out_valid", out_valid, 1'b0);
        n_checks++;
        if (result !== '0) begin
            n_fail++;
            $display("FAIL R11 mid reset: actual=%h expected=0", result);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule